// File: doc/BRIEF.md
# Multiplexed Three-Common LCD Driver

This block produces the drive levels for a passive liquid-crystal panel laid out as three backplane (common) lines and up to thirty-two segment lines, so that up to ninety-six pixels can be addressed. Each common owns one third of a frame. Every output is a 2-bit level code that selects one of four rail voltages through external analog switches. The codes follow a one-third bias scheme: a lit pixel sees the full supply across it, and an unlit pixel never sees more than one third of it. The drive polarity flips on alternate frames so that no pixel carries a net DC voltage.

Pixel data lives in a small segment memory holding one bit per pixel. It is written one column at a time: one segment line together with its three pixels. A mode register hands chosen segment lines to general-purpose use, where the driver holds them at ground. Four lines can be handed over one at a time and the remaining twelve in groups of four. Slot timing comes from a clock-enable tick. A 300 Hz tick gives three slots per 100 Hz frame and a full polarity period of two frames. A clock-stop input blanks every output to ground and restarts the sequence cleanly.

Top module: `lcd_mux_drv`

## Requirements
- R1: After reset, and until the first tick, every common and segment level code is 00 and every bit of `seg_gp_sel` is 0, meaning all lines are in segment mode.
- R2: Level codes are 00 = ground, 01 = one third, 10 = two thirds and 11 = supply. While driving, the common of the current slot is at 11 in the positive half-period and at 00 in the negative half-period. Every other common is at 01 in the positive half-period and at 10 in the negative half-period.
- R3: The first tick sampled after reset or after clock stop starts driving at slot 0 with positive polarity. Each later tick moves the slot 0→1→2. The tick after slot 2 returns to slot 0 and inverts the polarity. Outputs change in the cycle after the tick is sampled and stay stable between ticks.
- R4: A segment whose memory bit for the current slot's common is 1 is driven to 00 in the positive half-period and to 11 in the negative half-period. A segment whose bit is 0 is driven to 10 in the positive half-period and to 01 in the negative half-period.
- R5: With `wr_en` high, `wr_data[k]` is stored as the pixel of segment `wr_addr` on common k, and the stored value takes effect from the next cycle. Every other segment column is left unchanged.
- R6: While driving, every segment line in segment mode differs by exactly one level code from every inactive common.
- R7: The cycle after `clk_stop` is sampled high, all level codes are 00 and the slot and polarity return to their start values. Ticks are ignored while `clk_stop` is high. Segment memory keeps its contents and still accepts writes.
- R8: `cfg_we` loads the mode register. `cfg_bit_mode[j]` hands segment 16+j (0-based, j = 0..3) to general-purpose use. `cfg_grp_mode[g]` hands segments 20+4g to 23+4g as one group. Segments 0 to 15 never switch. `seg_gp_sel` shows the new mode from the next cycle.
- R9: A segment handed to general-purpose use always has level code 00. Its memory bits are kept, and they drive the line again once the line returns to segment mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slot-advance clock enable |
| clk_stop | input | 1 | Blank all outputs and restart the slot sequence |
| wr_en | input | 1 | Segment memory column write strobe |
| wr_addr | input | AW (5) | Segment column to write |
| wr_data | input | NCOM (3) | Pixel bits, bit k for common k |
| cfg_we | input | 1 | Mode register load strobe |
| cfg_bit_mode | input | NBIT (4) | Per-line handover for segments 16..19 |
| cfg_grp_mode | input | NGRP (3) | Group handover for segments 20..31 |
| com_lvl | output | 2*NCOM (6) | Common level codes, bits [2c+1:2c] for common c |
| seg_lvl | output | 2*NSEG (64) | Segment level codes, bits [2s+1:2s] for segment s |
| seg_gp_sel | output | NSEG (32) | 1 where a segment line is in general-purpose use |

## Verification
The bench builds the block with its defaults: three commons, thirty-two segments, four single-line handover bits starting at segment 16, and three groups of four. With these values every line class can be reached from the ports: lines that never switch, lines switched one at a time, and grouped lines. The full six-tick polarity cycle, every column address and the top group boundary at segment 31 are all covered. Random ticks, writes, mode loads and clock-stop pulses are compared cycle by cycle against a behavioural model, next to directed sequences for slot order, inversion, handover and restart after a stop.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

    typedef enum logic [1:0] {
        LVL_GND   = 2'd0,
        LVL_THIRD = 2'd1,
        LVL_TWO3  = 2'd2,
        LVL_VDD   = 2'd3
    } lvl_e;

    // Negative half-period mirrors the ladder: GND<->VDD, 1/3<->2/3.
    function automatic lvl_e lvl_mirror(input lvl_e l, input logic neg);
        return neg ? lvl_e'(~l) : l;
    endfunction

endpackage

// File: rtl/lcd_mux_timebase.sv
module lcd_mux_timebase #(
    parameter int NCOM = 3,
    localparam int SLOT_W = (NCOM > 1) ? $clog2(NCOM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clk_stop,
    output logic [SLOT_W-1:0] slot,
    output logic              pol,
    output logic              drive_en
);

    typedef struct packed {
        logic              en;
        logic              pol;
        logic [SLOT_W-1:0] slot;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clk_stop) begin
            st_d = '0;
        end else if (tick) begin
            if (!st_q.en) begin
                st_d.en = 1'b1;
            end else if (st_q.slot == SLOT_W'(NCOM - 1)) begin
                st_d.slot = '0;
                st_d.pol  = ~st_q.pol;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot     = st_q.slot;
    assign pol      = st_q.pol;
    assign drive_en = st_q.en;

endmodule

// File: rtl/lcd_mux_segram.sv
module lcd_mux_segram #(
    parameter int NCOM = 3,
    parameter int NSEG = 32,
    localparam int AW   = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int BITS = NCOM * NSEG
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [NCOM-1:0] wr_data,
    output logic [BITS-1:0] pix
);

    logic [BITS-1:0] pix_d, pix_q;

    always_comb begin
        pix_d = pix_q;
        if (wr_en && (32'(wr_addr) < NSEG)) begin
            pix_d[32'(wr_addr) * NCOM +: NCOM] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= pix_d;
    end

    assign pix = pix_q;

endmodule

// File: rtl/lcd_mux_pinmode.sv
module lcd_mux_pinmode #(
    parameter int NSEG     = 32,
    parameter int BIT_BASE = 16,
    parameter int NBIT     = 4,
    parameter int GRP_SZ   = 4,
    parameter int NGRP     = 3,
    localparam int GRP_BASE = BIT_BASE + NBIT,
    localparam int GRP_END  = GRP_BASE + GRP_SZ * NGRP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [NBIT-1:0] cfg_bit_mode,
    input  logic [NGRP-1:0] cfg_grp_mode,
    output logic [NSEG-1:0] gp_sel
);

    typedef struct packed {
        logic [NBIT-1:0] bits;
        logic [NGRP-1:0] grps;
    } mode_t;

    mode_t md_d, md_q;

    always_comb begin
        md_d = md_q;
        if (cfg_we) begin
            md_d.bits = cfg_bit_mode;
            md_d.grps = cfg_grp_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) md_q <= '0;
        else        md_q <= md_d;
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_line
        if (s >= BIT_BASE && s < GRP_BASE) begin : g_bit
            assign gp_sel[s] = md_q.bits[s - BIT_BASE];
        end else if (s >= GRP_BASE && s < GRP_END) begin : g_grp
            assign gp_sel[s] = md_q.grps[(s - GRP_BASE) / GRP_SZ];
        end else begin : g_fixed
            assign gp_sel[s] = 1'b0;
        end
    end

endmodule

// File: rtl/lcd_mux_levels.sv
module lcd_mux_levels
    import lcd_mux_pkg::*;
#(
    parameter int NCOM = 3,
    parameter int NSEG = 32,
    localparam int SLOT_W = (NCOM > 1) ? $clog2(NCOM) : 1
) (
    input  logic [SLOT_W-1:0]    slot,
    input  logic                 pol,
    input  logic                 drive_en,
    input  logic [NCOM*NSEG-1:0] pix,
    input  logic [NSEG-1:0]      gp_sel,
    output logic [2*NCOM-1:0]    com_lvl,
    output logic [2*NSEG-1:0]    seg_lvl
);

    always_comb begin
        lvl_e cv;
        for (int c = 0; c < NCOM; c++) begin
            cv = (slot == SLOT_W'(c)) ? LVL_VDD : LVL_THIRD;
            cv = lvl_mirror(cv, pol);
            com_lvl[2*c +: 2] = drive_en ? cv : LVL_GND;
        end
    end

    always_comb begin
        lvl_e            sv;
        logic [NCOM-1:0] col;
        for (int s = 0; s < NSEG; s++) begin
            col = pix[s*NCOM +: NCOM];
            sv  = col[slot] ? LVL_GND : LVL_TWO3;
            sv  = lvl_mirror(sv, pol);
            seg_lvl[2*s +: 2] = (drive_en && !gp_sel[s]) ? sv : LVL_GND;
        end
    end

endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv #(
    parameter int NCOM     = 3,
    parameter int NSEG     = 32,
    parameter int BIT_BASE = 16,
    parameter int NBIT     = 4,
    parameter int GRP_SZ   = 4,
    parameter int NGRP     = 3,
    localparam int AW     = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int SLOT_W = (NCOM > 1) ? $clog2(NCOM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clk_stop,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [NCOM-1:0]   wr_data,
    input  logic              cfg_we,
    input  logic [NBIT-1:0]   cfg_bit_mode,
    input  logic [NGRP-1:0]   cfg_grp_mode,
    output logic [2*NCOM-1:0] com_lvl,
    output logic [2*NSEG-1:0] seg_lvl,
    output logic [NSEG-1:0]   seg_gp_sel
);

    logic [SLOT_W-1:0]    slot;
    logic                 pol;
    logic                 drive_en;
    logic [NCOM*NSEG-1:0] pix;

    lcd_mux_timebase #(.NCOM(NCOM)) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clk_stop (clk_stop),
        .slot     (slot),
        .pol      (pol),
        .drive_en (drive_en)
    );

    lcd_mux_segram #(.NCOM(NCOM), .NSEG(NSEG)) u_segram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pix     (pix)
    );

    lcd_mux_pinmode #(
        .NSEG(NSEG), .BIT_BASE(BIT_BASE), .NBIT(NBIT),
        .GRP_SZ(GRP_SZ), .NGRP(NGRP)
    ) u_pinmode (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_bit_mode (cfg_bit_mode),
        .cfg_grp_mode (cfg_grp_mode),
        .gp_sel       (seg_gp_sel)
    );

    lcd_mux_levels #(.NCOM(NCOM), .NSEG(NSEG)) u_levels (
        .slot     (slot),
        .pol      (pol),
        .drive_en (drive_en),
        .pix      (pix),
        .gp_sel   (seg_gp_sel),
        .com_lvl  (com_lvl),
        .seg_lvl  (seg_lvl)
    );

endmodule

// File: rtl/lcd_mux_drv_chk.sv
module lcd_mux_drv_chk #(
    parameter int NCOM = 3,
    parameter int NSEG = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              clk_stop,
    input logic [2*NCOM-1:0] com_lvl,
    input logic [2*NSEG-1:0] seg_lvl,
    input logic [NSEG-1:0]   seg_gp_sel
);

    function automatic logic [NCOM-1:0] extreme_mask(input logic [2*NCOM-1:0] v);
        logic [NCOM-1:0] m;
        for (int c = 0; c < NCOM; c++) begin
            m[c] = (v[2*c +: 2] == 2'b00) || (v[2*c +: 2] == 2'b11);
        end
        return m;
    endfunction

    function automatic logic bias_ok(input logic [2*NCOM-1:0] cv,
                                     input logic [2*NSEG-1:0] sv,
                                     input logic [NSEG-1:0]   gp);
        logic ok;
        int   d;
        ok = 1'b1;
        for (int s = 0; s < NSEG; s++) begin
            for (int c = 0; c < NCOM; c++) begin
                d = int'(sv[2*s +: 2]) - int'(cv[2*c +: 2]);
                if (!gp[s] && cv[2*c +: 2] != 2'b00 && cv[2*c +: 2] != 2'b11 &&
                    d != 1 && d != -1) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    logic [NSEG-1:0] seg_nonzero;
    always_comb begin
        for (int s = 0; s < NSEG; s++) seg_nonzero[s] = |seg_lvl[2*s +: 2];
    end

    a_r7_stop_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop |=> (com_lvl == '0 && seg_lvl == '0));

    a_r2_one_active_common: assert property (@(posedge clk) disable iff (!rst_n)
        (com_lvl != '0) |-> $onehot(extreme_mask(com_lvl)));

    a_r9_gp_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_gp_sel & seg_nonzero) == '0);

    a_r6_unselected_bias: assert property (@(posedge clk) disable iff (!rst_n)
        (com_lvl != '0) |-> bias_ok(com_lvl, seg_lvl, seg_gp_sel));

    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clk_stop) |=> $stable(com_lvl));

endmodule

bind lcd_mux_drv lcd_mux_drv_chk #(.NCOM(NCOM), .NSEG(NSEG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .clk_stop   (clk_stop),
    .com_lvl    (com_lvl),
    .seg_lvl    (seg_lvl),
    .seg_gp_sel (seg_gp_sel)
);

// File: tb/lcd_mux_drv_bench.sv
`timescale 1ns/1ps
module lcd_mux_drv_bench;

    localparam int NCOM = 3;
    localparam int NSEG = 32;
    localparam int NBIT = 4;
    localparam int NGRP = 3;
    localparam int AW   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              clk_stop = 1'b0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [NCOM-1:0]   wr_data = '0;
    logic              cfg_we = 1'b0;
    logic [NBIT-1:0]   cfg_bit_mode = '0;
    logic [NGRP-1:0]   cfg_grp_mode = '0;
    logic [2*NCOM-1:0] com_lvl;
    logic [2*NSEG-1:0] seg_lvl;
    logic [NSEG-1:0]   seg_gp_sel;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    lcd_mux_drv u_lcd_mux_drv (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clk_stop(clk_stop),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_we(cfg_we), .cfg_bit_mode(cfg_bit_mode), .cfg_grp_mode(cfg_grp_mode),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl), .seg_gp_sel(seg_gp_sel)
    );

    // Behavioural reference state
    int m_en, m_slot, m_pol;
    bit m_ram [NSEG][NCOM];
    bit [NBIT-1:0] m_bm;
    bit [NGRP-1:0] m_gm;

    task automatic chk(input string tag, input logic [63:0] a, input logic [63:0] e);
        n_tests++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, a, e);
        end
    endtask

    function automatic int exp_gp(input int s);
        if (s >= 16 && s < 20) return int'(m_bm[s-16]);
        if (s >= 20 && s < 32) return int'(m_gm[(s-20)/4]);
        return 0;
    endfunction

    function automatic int exp_com(input int c);
        int v;
        if (m_en == 0) return 0;
        v = (c == m_slot) ? 3 : 1;
        return (m_pol != 0) ? 3 - v : v;
    endfunction

    function automatic int exp_seg(input int s);
        int v;
        if (m_en == 0 || exp_gp(s) != 0) return 0;
        v = m_ram[s][m_slot] ? 0 : 2;
        return (m_pol != 0) ? 3 - v : v;
    endfunction

    task automatic model_update();
        if (clk_stop) begin
            m_en = 0; m_slot = 0; m_pol = 0;
        end else if (tick) begin
            if (m_en == 0) m_en = 1;
            else if (m_slot == NCOM-1) begin m_slot = 0; m_pol = 1 - m_pol; end
            else m_slot++;
        end
        if (wr_en) for (int k = 0; k < NCOM; k++) m_ram[int'(wr_addr)][k] = wr_data[k];
        if (cfg_we) begin m_bm = cfg_bit_mode; m_gm = cfg_grp_mode; end
    endtask

    task automatic compare_all();
        logic [63:0] ec, es, eg;
        bit ok;
        int d;
        ec = '0; es = '0; eg = '0;
        for (int c = 0; c < NCOM; c++) ec[2*c +: 2] = 2'(exp_com(c));
        for (int s = 0; s < NSEG; s++) begin
            es[2*s +: 2] = 2'(exp_seg(s));
            eg[s] = exp_gp(s) != 0;
        end
        chk("R2 commons", 64'(com_lvl), ec);
        chk("R4 segments", 64'(seg_lvl), es);
        chk("R8 handover", 64'(seg_gp_sel), eg);
        ok = 1;
        if (m_en != 0) begin
            for (int s = 0; s < NSEG; s++)
                for (int c = 0; c < NCOM; c++)
                    if (exp_gp(s) == 0 && c != m_slot) begin
                        d = int'(seg_lvl[2*s +: 2]) - int'(com_lvl[2*c +: 2]);
                        if (d != 1 && d != -1) ok = 0;
                    end
        end
        chk("R6 unselected bias", 64'(ok), 64'd1);
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_en = 0; m_slot = 0; m_pol = 0; m_bm = '0; m_gm = '0;
        for (int s = 0; s < NSEG; s++) for (int k = 0; k < NCOM; k++) m_ram[s][k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 com", 64'(com_lvl), 64'd0);
        chk("R1 seg", 64'(seg_lvl), 64'd0);
        chk("R1 mode", 64'(seg_gp_sel), 64'd0);
        step();

        // R5 column writes
        wr_en = 1; wr_addr = 5'd0; wr_data = 3'b101; step();
        wr_addr = 5'd5; wr_data = 3'b010; step();
        wr_en = 0;
        chk("R1 no tick yet", 64'(com_lvl), 64'd0);

        // R3 slot order and inversion
        tick = 1; step(); tick = 0;
        chk("R3 slot0 pos", 64'(com_lvl), 64'b01_01_11);
        chk("R4 seg0 lit pos", 64'(seg_lvl[1:0]), 64'b00);
        chk("R5 seg5 slot0", 64'(seg_lvl[11:10]), 64'b10);
        step();
        chk("R3 stable", 64'(com_lvl), 64'b01_01_11);
        tick = 1; step(); tick = 0;
        chk("R3 slot1 pos", 64'(com_lvl), 64'b01_11_01);
        chk("R5 seg5 slot1", 64'(seg_lvl[11:10]), 64'b00);
        tick = 1; step(); tick = 0;
        chk("R3 slot2 pos", 64'(com_lvl), 64'b11_01_01);
        tick = 1; step(); tick = 0;
        chk("R3 slot0 neg", 64'(com_lvl), 64'b10_10_00);
        chk("R4 seg0 lit neg", 64'(seg_lvl[1:0]), 64'b11);
        chk("R4 seg1 dark neg", 64'(seg_lvl[3:2]), 64'b01);

        // R8 / R9 handover
        wr_en = 1; wr_addr = 5'd17; wr_data = 3'b111;
        cfg_we = 1; cfg_bit_mode = 4'b0010; cfg_grp_mode = 3'b100; step();
        wr_en = 0; cfg_we = 0;
        chk("R8 mode map", 64'(seg_gp_sel), 64'hF002_0000);
        chk("R9 gp line low", 64'(seg_lvl[35:34]), 64'b00);
        chk("R9 group line low", 64'(seg_lvl[63:62]), 64'b00);
        cfg_we = 1; cfg_bit_mode = '0; cfg_grp_mode = '0; step(); cfg_we = 0;
        chk("R9 bits kept", 64'(seg_lvl[35:34]), 64'b11);

        // R7 clock stop
        clk_stop = 1; tick = 1; step();
        chk("R7 blank com", 64'(com_lvl), 64'd0);
        chk("R7 blank seg", 64'(seg_lvl), 64'd0);
        wr_en = 1; wr_addr = 5'd3; wr_data = 3'b001; step(); wr_en = 0;
        step();
        clk_stop = 0; tick = 0; step();
        chk("R7 still blank", 64'(com_lvl), 64'd0);
        tick = 1; step(); tick = 0;
        chk("R7 restart", 64'(com_lvl), 64'b01_01_11);
        chk("R7 write kept", 64'(seg_lvl[7:6]), 64'b00);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            tick     = ($urandom % 4) == 0;
            clk_stop = ($urandom % 60) == 0;
            wr_en    = ($urandom % 3) == 0;
            wr_addr  = AW'($urandom_range(0, NSEG-1));
            wr_data  = NCOM'($urandom);
            cfg_we   = ($urandom % 40) == 0;
            cfg_bit_mode = NBIT'($urandom);
            cfg_grp_mode = NGRP'($urandom);
            step();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule